// File: doc/BRIEF.md
# Link Management Packet Framer and Checker

This block sits beside a link-layer arbiter/multiplexer. It builds and checks the one-doubleword control packets that ask the link partner to move a virtual link state machine, and that report that a move has happened. On the transmit side, a request or status command is accepted through a valid/ready handshake. It is packed into a 32-bit packet, and that packet is written four times into the lowest 128 bits of a 528-bit flit. The remaining bits of the flit are zero.

On the receive side, each incoming flit is checked in three ways. The four copies must be identical, the message code must be correct, and the padding bits must be zero. A flit that passes is reported as either a request or a status, together with its channel and state fields. A flit that fails any check gives a one-cycle retrain pulse and is not reported. The block also keeps a flag for an outstanding request. While this flag is set, no new request can be sent. The flag clears when a status arrives whose channel and state both match the request, and it also clears on a retrain.

Top module: `lmp_link_mgr`

## Requirements
- R1: After reset, `tx_flit_valid`, `rx_req_valid`, `rx_sts_valid`, `retrain` and `req_pending` are 0, and `tx_ready` is 1.
- R2: One cycle after a transmit handshake (`tx_valid` and `tx_ready` both high), `tx_flit_valid` is 1. At that point bits [32*i+31:32*i] of `tx_flit`, for i = 0..3, each hold the packet. The packet layout is: byte 0 (bits 7:0) = channel, byte 1 (bits 15:8) = 8'h08, byte 2 bit 7 (bit 23) = 1 for a request and 0 for a status, byte 2 bits 3:0 (bits 19:16) = state, and all other bits 0.
- R3: Bits [527:128] of `tx_flit` are always 0.
- R4: One cycle after a valid received flit, `rx_req_valid` is 1 if bit 23 is set, and `rx_sts_valid` is 1 if bit 23 is clear. `rx_chan` and `rx_state` carry bits 7:0 and 19:16 of the packet. The two valid outputs are never high together.
- R5: If the four received copies are not bit-identical, `retrain` is 1 one cycle later, and neither `rx_req_valid` nor `rx_sts_valid` is raised.
- R6: If byte 1 of a received flit is not 8'h08, `retrain` is raised and the flit is not reported.
- R7: If any bit in [527:128] of a received flit is nonzero, `retrain` is raised and the flit is not reported.
- R8: `retrain` is a single-cycle pulse for each bad flit. It is high only in the cycle after a bad flit was presented.
- R9: `req_pending` becomes 1 one cycle after a request handshake. While it is 1, `tx_ready` is 0 whenever `tx_is_req` is 1, and stays 1 for status commands.
- R10: `req_pending` clears in the same cycle that a received status with matching channel and state is reported. A status that does not match, or a received request, leaves it set.
- R11: A retrain clears `req_pending`, and takes priority over a request issued in the same cycle.
- R12: `tx_flit_valid` is 1 only in the one cycle that follows a handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transmit command valid |
| tx_ready | output | 1 | Transmit command accepted |
| tx_is_req | input | 1 | 1 = request, 0 = status |
| tx_chan | input | 8 | Channel field to send |
| tx_state | input | 4 | Virtual link state to send |
| tx_flit_valid | output | 1 | Transmit flit valid |
| tx_flit | output | 528 | Transmit flit |
| rx_flit_valid | input | 1 | Received flit valid |
| rx_flit | input | 528 | Received flit |
| rx_req_valid | output | 1 | Good received request |
| rx_sts_valid | output | 1 | Good received status |
| rx_chan | output | 8 | Received channel field |
| rx_state | output | 4 | Received state field |
| retrain | output | 1 | Link retrain pulse on bad flit |
| req_pending | output | 1 | Own request awaiting status |

## Verification
Every result appears exactly one clock edge after its stimulus. This applies to the transmit flit, the receive report, the retrain pulse and the change to the pending flag. `tx_ready` is the one exception: it is combinational from `tx_is_req` and the registered flag, so it is read in the same cycle as the stimulus. The bench drives inputs on the falling edge. After the single rising edge that follows, it samples on the next falling edge. It then waits one further falling edge to confirm that pulses have dropped. `tx_ready` is read 1 ns after its inputs change.

// File: rtl/lmp_pkg.sv
package lmp_pkg;

    localparam int PKT_W   = 32;
    localparam int CHAN_W  = 8;
    localparam int STATE_W = 4;
    localparam logic [7:0] MSG_CODE = 8'h08;

    // Packet layout, MSB first: byte3 reserved, byte2 {kind, 3'b0, state},
    // byte1 message code, byte0 channel.
    typedef struct packed {
        logic [7:0]         rsvd;
        logic               is_req;
        logic [2:0]         zero;
        logic [STATE_W-1:0] state;
        logic [7:0]         code;
        logic [CHAN_W-1:0]  chan;
    } lmp_pkt_t;

    typedef struct packed {
        logic               good;
        logic               bad;
        logic               is_req;
        logic [CHAN_W-1:0]  chan;
        logic [STATE_W-1:0] state;
    } lmp_rx_dec_t;

    function automatic lmp_pkt_t lmp_build(input logic is_req,
                                           input logic [CHAN_W-1:0] chan,
                                           input logic [STATE_W-1:0] state);
        lmp_pkt_t p;
        p.rsvd   = '0;
        p.is_req = is_req;
        p.zero   = '0;
        p.state  = state;
        p.code   = MSG_CODE;
        p.chan   = chan;
        return p;
    endfunction

endpackage

// File: rtl/lmp_tx_framer.sv
module lmp_tx_framer
    import lmp_pkg::*;
#(
    parameter int FLIT_W = 528,
    parameter int COPIES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fire,
    input  logic                is_req,
    input  logic [CHAN_W-1:0]   chan,
    input  logic [STATE_W-1:0]  state,
    output logic                flit_valid,
    output logic [FLIT_W-1:0]   flit
);
    localparam int FILL_W = COPIES * PKT_W;

    lmp_pkt_t            pkt;
    logic [FLIT_W-1:0]   next_flit;

    assign pkt = lmp_build(is_req, chan, state);

    always_comb begin
        next_flit = '0;
        for (int i = 0; i < COPIES; i++) begin
            next_flit[i*PKT_W +: PKT_W] = pkt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flit_valid <= 1'b0;
            flit       <= '0;
        end else begin
            flit_valid <= fire;
            if (fire) begin
                flit <= next_flit;
            end
        end
    end

    initial begin
        if (FILL_W > FLIT_W) $error("copies exceed flit width");
    end
endmodule

// File: rtl/lmp_rx_checker.sv
module lmp_rx_checker
    import lmp_pkg::*;
#(
    parameter int FLIT_W = 528,
    parameter int COPIES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flit_valid,
    input  logic [FLIT_W-1:0]   flit,
    output lmp_rx_dec_t         dec,
    output logic                req_valid,
    output logic                sts_valid,
    output logic [CHAN_W-1:0]   chan,
    output logic [STATE_W-1:0]  state,
    output logic                retrain
);
    localparam int FILL_W = COPIES * PKT_W;
    localparam int PAD_W  = FLIT_W - FILL_W;

    lmp_pkt_t           copy0;
    logic [COPIES-1:0]  same;
    logic               pad_bad;
    logic               code_bad;

    assign copy0 = flit[PKT_W-1:0];

    generate
        for (genvar g = 0; g < COPIES; g++) begin : g_cmp
            if (g == 0) begin : g_ref
                assign same[g] = 1'b1;
            end else begin : g_oth
                assign same[g] = (flit[g*PKT_W +: PKT_W] == copy0);
            end
        end
        if (PAD_W > 0) begin : g_pad
            assign pad_bad = |flit[FLIT_W-1:FILL_W];
        end else begin : g_nopad
            assign pad_bad = 1'b0;
        end
    endgenerate

    assign code_bad = (copy0.code != MSG_CODE);

    always_comb begin
        dec.bad    = flit_valid && (!(&same) || code_bad || pad_bad);
        dec.good   = flit_valid && !dec.bad;
        dec.is_req = copy0.is_req;
        dec.chan   = copy0.chan;
        dec.state  = copy0.state;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            sts_valid <= 1'b0;
            chan      <= '0;
            state     <= '0;
            retrain   <= 1'b0;
        end else begin
            req_valid <= dec.good &&  dec.is_req;
            sts_valid <= dec.good && !dec.is_req;
            retrain   <= dec.bad;
            if (dec.good) begin
                chan  <= dec.chan;
                state <= dec.state;
            end
        end
    end
endmodule

// File: rtl/lmp_pending_track.sv
module lmp_pending_track
    import lmp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_fire,
    input  logic [CHAN_W-1:0]   tx_chan,
    input  logic [STATE_W-1:0]  tx_state,
    input  lmp_rx_dec_t         dec,
    output logic                pending
);
    logic [CHAN_W-1:0]  want_chan;
    logic [STATE_W-1:0] want_state;
    logic               hit;

    assign hit = dec.good && !dec.is_req &&
                 (dec.chan == want_chan) && (dec.state == want_state);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending    <= 1'b0;
            want_chan  <= '0;
            want_state <= '0;
        end else if (dec.bad) begin
            pending <= 1'b0;
        end else if (req_fire) begin
            pending    <= 1'b1;
            want_chan  <= tx_chan;
            want_state <= tx_state;
        end else if (pending && hit) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/lmp_link_mgr.sv
module lmp_link_mgr
    import lmp_pkg::*;
#(
    parameter int FLIT_W = 528,
    parameter int COPIES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tx_valid,
    output logic                tx_ready,
    input  logic                tx_is_req,
    input  logic [7:0]          tx_chan,
    input  logic [3:0]          tx_state,
    output logic                tx_flit_valid,
    output logic [FLIT_W-1:0]   tx_flit,
    input  logic                rx_flit_valid,
    input  logic [FLIT_W-1:0]   rx_flit,
    output logic                rx_req_valid,
    output logic                rx_sts_valid,
    output logic [7:0]          rx_chan,
    output logic [3:0]          rx_state,
    output logic                retrain,
    output logic                req_pending
);
    lmp_rx_dec_t dec;
    logic        fire;

    assign tx_ready = !(tx_is_req && req_pending);
    assign fire     = tx_valid && tx_ready;

    lmp_tx_framer #(.FLIT_W(FLIT_W), .COPIES(COPIES)) u_tx (
        .clk(clk), .rst(rst), .fire(fire), .is_req(tx_is_req),
        .chan(tx_chan), .state(tx_state),
        .flit_valid(tx_flit_valid), .flit(tx_flit)
    );

    lmp_rx_checker #(.FLIT_W(FLIT_W), .COPIES(COPIES)) u_rx (
        .clk(clk), .rst(rst), .flit_valid(rx_flit_valid), .flit(rx_flit),
        .dec(dec), .req_valid(rx_req_valid), .sts_valid(rx_sts_valid),
        .chan(rx_chan), .state(rx_state), .retrain(retrain)
    );

    lmp_pending_track u_pend (
        .clk(clk), .rst(rst), .req_fire(fire && tx_is_req),
        .tx_chan(tx_chan), .tx_state(tx_state), .dec(dec),
        .pending(req_pending)
    );
endmodule

// File: rtl/lmp_link_mgr_chk.sv
module lmp_link_mgr_chk #(
    parameter int FLIT_W = 528,
    parameter int COPIES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              tx_is_req,
    input logic              tx_flit_valid,
    input logic [FLIT_W-1:0] tx_flit,
    input logic              rx_flit_valid,
    input logic              rx_req_valid,
    input logic              rx_sts_valid,
    input logic              retrain,
    input logic              req_pending
);
    localparam int FILL_W = COPIES * 32;

    // R2
    flit_after_handshake_chk: assert property (@(posedge clk) disable iff (rst)
        tx_flit_valid |-> $past(tx_valid && tx_ready));

    // R3
    pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        tx_flit[FLIT_W-1:FILL_W] == '0);

    // R4
    rx_kind_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_req_valid && rx_sts_valid));

    // R5
    retrain_no_report_chk: assert property (@(posedge clk) disable iff (rst)
        retrain |-> !rx_req_valid && !rx_sts_valid);

    // R8
    retrain_src_chk: assert property (@(posedge clk) disable iff (rst)
        retrain |-> $past(rx_flit_valid));

    // R9
    block_second_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req_pending && tx_is_req) |-> !tx_ready);

    // R11
    retrain_clears_chk: assert property (@(posedge clk) disable iff (rst)
        retrain |-> !req_pending);
endmodule

bind lmp_link_mgr lmp_link_mgr_chk #(.FLIT_W(FLIT_W), .COPIES(COPIES)) u_chk (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_is_req(tx_is_req), .tx_flit_valid(tx_flit_valid), .tx_flit(tx_flit),
    .rx_flit_valid(rx_flit_valid), .rx_req_valid(rx_req_valid),
    .rx_sts_valid(rx_sts_valid), .retrain(retrain), .req_pending(req_pending)
);

// File: tb/sim_lmp_link_mgr.sv
module sim_lmp_link_mgr;
    logic         clk = 1'b0;
    logic         rst;
    logic         tx_valid, tx_ready, tx_is_req;
    logic [7:0]   tx_chan;
    logic [3:0]   tx_state;
    logic         tx_flit_valid;
    logic [527:0] tx_flit;
    logic         rx_flit_valid;
    logic [527:0] rx_flit;
    logic         rx_req_valid, rx_sts_valid, retrain, req_pending;
    logic [7:0]   rx_chan;
    logic [3:0]   rx_state;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    lmp_link_mgr u0 (
        .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_is_req(tx_is_req), .tx_chan(tx_chan), .tx_state(tx_state),
        .tx_flit_valid(tx_flit_valid), .tx_flit(tx_flit),
        .rx_flit_valid(rx_flit_valid), .rx_flit(rx_flit),
        .rx_req_valid(rx_req_valid), .rx_sts_valid(rx_sts_valid),
        .rx_chan(rx_chan), .rx_state(rx_state), .retrain(retrain),
        .req_pending(req_pending)
    );

    // {is_req, chan, state, expected packet}
    localparam logic [44:0] VEC [5] = '{
        {1'b0, 8'h01, 4'h1, 32'h0001_0801},
        {1'b1, 8'h02, 4'h5, 32'h0085_0802},
        {1'b0, 8'hFF, 4'hF, 32'h000F_08FF},
        {1'b1, 8'h80, 4'h0, 32'h0080_0880},
        {1'b0, 8'h00, 4'hA, 32'h000A_0800}
    };

    function automatic logic [527:0] mk(input logic [31:0] dw);
        return {400'b0, dw, dw, dw, dw};
    endfunction

    function automatic logic [31:0] pk(input logic r, input logic [7:0] c,
                                       input logic [3:0] s);
        return {8'h00, r, 3'b000, s, 8'h08, c};
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [527:0] act, input logic [527:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_tx(input logic r, input logic [7:0] c, input logic [3:0] s);
        @(negedge clk);
        tx_valid = 1'b1; tx_is_req = r; tx_chan = c; tx_state = s;
        @(negedge clk);
        tx_valid = 1'b0; tx_is_req = 1'b0;
    endtask

    task automatic send_rx(input logic [527:0] f);
        @(negedge clk);
        rx_flit_valid = 1'b1; rx_flit = f;
        @(negedge clk);
        rx_flit_valid = 1'b0; rx_flit = '0;
    endtask

    task automatic bad_flit(input logic [527:0] f, input string tag);
        send_rx(f);
        chk(retrain === 1'b1, tag, retrain, 1);
        chk(!rx_req_valid && !rx_sts_valid, tag, {rx_req_valid, rx_sts_valid}, 0);
        chk(req_pending === 1'b0, {tag, " R11 pending"}, req_pending, 0);
        @(negedge clk);
        chk(retrain === 1'b0, "R8 pulse ends", retrain, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; tx_valid = 1'b0; tx_is_req = 1'b1; tx_chan = '0; tx_state = '0;
        rx_flit_valid = 1'b0; rx_flit = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1
        chk(!tx_flit_valid && !rx_req_valid && !rx_sts_valid && !retrain && !req_pending,
            "R1 outputs", {tx_flit_valid, rx_req_valid, rx_sts_valid, retrain, req_pending}, 0);
        chk(tx_ready === 1'b1, "R1 ready", tx_ready, 1);
        tx_is_req = 1'b0;

        // Vector table walk
        foreach (VEC[i]) begin
            logic       r;
            logic [7:0] c;
            logic [3:0] s;
            {r, c, s} = VEC[i][44:32];
            @(negedge clk);
            tx_valid = 1'b1; tx_is_req = r; tx_chan = c; tx_state = s;
            #1 chk(tx_ready === 1'b1, "R9 ready idle", tx_ready, 1);
            @(negedge clk);
            tx_valid = 1'b0; tx_is_req = 1'b0;
            chk(tx_flit_valid === 1'b1, "R2 valid", tx_flit_valid, 1);
            chk(tx_flit === mk(VEC[i][31:0]), "R2 R3 flit", tx_flit, mk(VEC[i][31:0]));
            chk(req_pending === r, "R9 pending", req_pending, r);
            if (r) begin
                send_rx(mk(pk(1'b0, c, s)));
                chk(rx_sts_valid === 1'b1 && rx_chan === c && rx_state === s,
                    "R4 status", {rx_sts_valid, rx_chan, rx_state}, {1'b1, c, s});
                chk(req_pending === 1'b0, "R10 match clears", req_pending, 0);
            end else begin
                @(negedge clk);
            end
            chk(tx_flit_valid === 1'b0, "R12 one cycle", tx_flit_valid, 0);
        end

        // R9 blocking
        send_tx(1'b1, 8'h05, 4'h3);
        tx_is_req = 1'b1;
        #1 chk(tx_ready === 1'b0, "R9 blocked", tx_ready, 0);
        tx_is_req = 1'b0;
        #1 chk(tx_ready === 1'b1, "R9 status ok", tx_ready, 1);

        // R10 non-matching status, partner request
        send_rx(mk(pk(1'b0, 8'h05, 4'h4)));
        chk(rx_sts_valid === 1'b1, "R4 sts", rx_sts_valid, 1);
        chk(req_pending === 1'b1, "R10 mismatch keeps", req_pending, 1);
        send_rx(mk(pk(1'b1, 8'h05, 4'h3)));
        chk(rx_req_valid === 1'b1 && rx_sts_valid === 1'b0 && rx_chan === 8'h05 && rx_state === 4'h3,
            "R4 req", {rx_req_valid, rx_sts_valid, rx_chan, rx_state}, {2'b10, 8'h05, 4'h3});
        chk(req_pending === 1'b1, "R10 req keeps", req_pending, 1);

        // R5 copy mismatch (also clears pending, R11)
        begin
            logic [527:0] f;
            f = mk(pk(1'b0, 8'h05, 4'h3));
            f[70] = ~f[70];
            bad_flit(f, "R5 copy mismatch");
        end

        // R6 wrong code
        send_tx(1'b1, 8'h09, 4'h2);
        chk(req_pending === 1'b1, "R9 set again", req_pending, 1);
        bad_flit(mk({8'h00, 8'h02, 8'h07, 8'h09}), "R6 bad code");

        // R7 padding
        begin
            logic [527:0] f;
            f = mk(pk(1'b1, 8'h01, 4'h1));
            f[527] = 1'b1;
            bad_flit(f, "R7 pad");
        end

        // R11 retrain beats same-cycle request
        @(negedge clk);
        tx_valid = 1'b1; tx_is_req = 1'b1; tx_chan = 8'h0C; tx_state = 4'h6;
        rx_flit_valid = 1'b1; rx_flit = mk(pk(1'b0, 8'h0C, 4'h6)) ^ 528'h1_0000_0000;
        @(negedge clk);
        tx_valid = 1'b0; tx_is_req = 1'b0; rx_flit_valid = 1'b0; rx_flit = '0;
        chk(retrain === 1'b1 && req_pending === 1'b0, "R11 priority",
            {retrain, req_pending}, 2'b10);
        chk(tx_flit_valid === 1'b1, "R2 flit still sent", tx_flit_valid, 1);

        // R12 idle
        @(negedge clk);
        chk(tx_flit_valid === 1'b0, "R12 idle", tx_flit_valid, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule